// File: doc/BRIEF.md
# Address Table Violation Capture

This block watches the violation strobes coming out of an address-table lookup engine and keeps the first one it sees. For that event it stores the violation kind, the source port, the database number, the MAC address and the port vector. While a violation is held, an interrupt line stays high so that the host knows there is something to collect. Any violation that arrives while one is already held is discarded.

The host collects the stored violation through the same command and result registers it uses for normal table entries. It writes a special get-and-clear command code. The block then goes busy for a fixed number of cycles and copies the stored details into the result registers. The violation kind appears as flag bits beside the command. The source port number occupies the low field of the data word, where an entry state would normally sit. The store is then emptied, so the next violation can be caught.

Top module: `atu_viol_capture`

## Requirements
- R1: An event strobe with at least one kind bit set is captured when nothing is held, and `irq_o` is high from the next cycle on.
- R2: While a violation is held and no get-and-clear is accepted, further events are discarded and do not change what is later reported.
- R3: A command is accepted when `cmd_wr_i` is high and `busy_o` is low. An accepted get-and-clear (`cmd_op_i` = 7) raises `busy_o` for exactly `BUSY_CYC` cycles, starting the cycle after acceptance.
- R4: After a get-and-clear of a held violation, `flags_o` shows its kind bits (bit 0 age-out, bit 1 member, bit 2 miss, bit 3 table full). `res_data_o[3:0]` shows the source port and `res_data_o[14:4]` the port vector. `res_mac_o` shows the MAC address and `res_db_o` the database number.
- R5: An accepted get-and-clear empties the store, so `irq_o` is low from the next cycle unless a new event is captured in the acceptance cycle.
- R6: An event that arrives in the same cycle that a get-and-clear is accepted is captured as the next held violation. The violation being read out is still the one reported.
- R7: The flags stay unchanged until the next accepted command. Any accepted command other than get-and-clear clears them to zero and leaves the result data registers unchanged.
- R8: A get-and-clear with nothing held reports all flags, `res_data_o`, `res_mac_o` and `res_db_o` as zero.
- R9: A command written while `busy_o` is high is ignored. It does not change the flags, the results, the held violation or the busy duration.
- R10: An event strobe whose kind bits are all zero is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_valid_i | input | 1 | Violation event strobe |
| ev_kind_i | input | 4 | Kind bits: 0 age-out, 1 member, 2 miss, 3 table full |
| ev_src_i | input | SRC_W (4) | Source port number |
| ev_db_i | input | DB_W (12) | Database number |
| ev_mac_i | input | MAC_W (48) | Offending MAC address |
| ev_pvec_i | input | NPORTS (11) | Port vector |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_op_i | input | OP_W (3) | Command code, 7 is get-and-clear |
| busy_o | output | 1 | Command in progress |
| flags_o | output | 4 | Violation kind flags of the last get-and-clear |
| res_data_o | output | SRC_W+NPORTS (15) | Port vector above source port |
| res_mac_o | output | MAC_W (48) | Reported MAC address |
| res_db_o | output | DB_W (12) | Reported database number |
| irq_o | output | 1 | Violation pending interrupt |

## Verification
The hardest case to reach is the one where a new violation arrives in the same cycle that a get-and-clear is accepted. At that edge the store has to give up the old violation and take the new one together. The stimulus holds one violation, then drives the command write and a second event strobe on the same negative edge. The bench then expects the first violation to be reported, the interrupt to stay high, and a second get-and-clear to return the second violation. A related case issues a get-and-clear while `busy_o` is still high and a fresh violation is held. The interrupt must survive that ignored command, and the busy window must not be extended.

// File: rtl/atu_viol_capture.sv
module atu_viol_capture #(
  parameter int NPORTS    = 11,
  parameter int DB_W      = 12,
  parameter int MAC_W     = 48,
  parameter int SRC_W     = 4,
  parameter int OP_W      = 3,
  parameter int BUSY_CYC  = 3,
  parameter int GETCLR_OP = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ev_valid_i,
  input  logic [3:0]              ev_kind_i,
  input  logic [SRC_W-1:0]        ev_src_i,
  input  logic [DB_W-1:0]         ev_db_i,
  input  logic [MAC_W-1:0]        ev_mac_i,
  input  logic [NPORTS-1:0]       ev_pvec_i,
  input  logic                    cmd_wr_i,
  input  logic [OP_W-1:0]         cmd_op_i,
  output logic                    busy_o,
  output logic [3:0]              flags_o,
  output logic [SRC_W+NPORTS-1:0] res_data_o,
  output logic [MAC_W-1:0]        res_mac_o,
  output logic [DB_W-1:0]         res_db_o,
  output logic                    irq_o
);
  localparam int DATA_W = SRC_W + NPORTS;
  localparam int CNT_W  = $clog2(BUSY_CYC + 1);

  logic              held;
  logic [3:0]        h_kind;
  logic [SRC_W-1:0]  h_src;
  logic [DB_W-1:0]   h_db;
  logic [MAC_W-1:0]  h_mac;
  logic [NPORTS-1:0] h_pvec;
  logic [CNT_W-1:0]  cnt;

  logic accept, getclr, take;

  assign busy_o = (cnt != '0);
  assign accept = cmd_wr_i && !busy_o;
  assign getclr = accept && (cmd_op_i == OP_W'(GETCLR_OP));
  assign take   = ev_valid_i && (ev_kind_i != 4'b0) && (!held || getclr);
  assign irq_o  = held;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      held   <= 1'b0;
      h_kind <= '0;
      h_src  <= '0;
      h_db   <= '0;
      h_mac  <= '0;
      h_pvec <= '0;
    end else if (take) begin
      held   <= 1'b1;
      h_kind <= ev_kind_i;
      h_src  <= ev_src_i;
      h_db   <= ev_db_i;
      h_mac  <= ev_mac_i;
      h_pvec <= ev_pvec_i;
    end else if (getclr) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt        <= '0;
      flags_o    <= '0;
      res_data_o <= '0;
      res_mac_o  <= '0;
      res_db_o   <= '0;
    end else if (getclr) begin
      cnt        <= CNT_W'(BUSY_CYC);
      flags_o    <= held ? h_kind : 4'b0;
      res_data_o <= held ? {h_pvec, h_src} : DATA_W'(0);
      res_mac_o  <= held ? h_mac : '0;
      res_db_o   <= held ? h_db : '0;
    end else begin
      if (accept) flags_o <= 4'b0;
      if (busy_o) cnt <= cnt - 1'b1;
    end
  end

  // R1
  ev_sets_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && ev_kind_i != 4'b0) |=> irq_o);

  // R2
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !getclr) |=> ($stable(h_mac) && $stable(h_kind) && $stable(h_src)));

  // R5
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (getclr && !(ev_valid_i && ev_kind_i != 4'b0)) |=> !irq_o);

  // R7
  flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_op_i != OP_W'(GETCLR_OP)) |=> (flags_o == 4'b0 && $stable(res_mac_o)));

  // R8
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (getclr && !irq_o) |=> (flags_o == 4'b0 && res_data_o == '0 && res_mac_o == '0));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_wr_i) |=> ($stable(flags_o) && $stable(res_mac_o) && $stable(res_db_o)));

  generate
    if (BUSY_CYC >= 2) begin : g_busy_len
      // R3
      busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |=> busy_o);
    end
  endgenerate
endmodule

// File: tb/test_atu_viol_capture.sv
module test_atu_viol_capture;
  localparam int NP = 11, DBW = 12, MW = 48, SW = 4, BC = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic ev_valid = 0;
  logic [3:0] ev_kind = 0;
  logic [SW-1:0] ev_src = 0;
  logic [DBW-1:0] ev_db = 0;
  logic [MW-1:0] ev_mac = 0;
  logic [NP-1:0] ev_pvec = 0;
  logic cmd_wr = 0;
  logic [2:0] cmd_op = 0;
  logic busy, irq;
  logic [3:0] flags;
  logic [SW+NP-1:0] rdata;
  logic [MW-1:0] rmac;
  logic [DBW-1:0] rdb;

  atu_viol_capture i_atu_viol_capture (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_kind_i(ev_kind),
    .ev_src_i(ev_src), .ev_db_i(ev_db), .ev_mac_i(ev_mac), .ev_pvec_i(ev_pvec),
    .cmd_wr_i(cmd_wr), .cmd_op_i(cmd_op), .busy_o(busy), .flags_o(flags),
    .res_data_o(rdata), .res_mac_o(rmac), .res_db_o(rdb), .irq_o(irq));

  int errors = 0, checks = 0;
  string cur = "R1";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_held; logic [3:0] m_kind; logic [SW-1:0] m_src; logic [DBW-1:0] m_db;
  logic [MW-1:0] m_mac; logic [NP-1:0] m_pvec;
  int m_cnt; logic [3:0] m_flags; logic [SW+NP-1:0] m_data; logic [MW-1:0] m_rmac;
  logic [DBW-1:0] m_rdb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_held = 0; m_kind = 0; m_src = 0; m_db = 0; m_mac = 0; m_pvec = 0;
      m_cnt = 0; m_flags = 0; m_data = 0; m_rmac = 0; m_rdb = 0;
    end else begin
      bit acc, gc, tk;
      acc = cmd_wr && (m_cnt == 0);
      gc = acc && cmd_op == 3'd7;
      tk = ev_valid && ev_kind != 0 && (!m_held || gc);
      if (gc) begin
        m_cnt = BC;
        m_flags = m_held ? m_kind : 4'h0;
        m_data = m_held ? {m_pvec, m_src} : '0;
        m_rmac = m_held ? m_mac : '0;
        m_rdb = m_held ? m_db : '0;
        m_held = 0;
      end else begin
        if (acc) m_flags = 0;
        if (m_cnt > 0) m_cnt--;
      end
      if (tk) begin
        m_held = 1; m_kind = ev_kind; m_src = ev_src; m_db = ev_db;
        m_mac = ev_mac; m_pvec = ev_pvec;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cur, busy, m_cnt != 0, "busy");
    chk(cur, irq, m_held, "irq");
    chk(cur, flags, m_flags, "flags");
    chk(cur, rdata, m_data, "data");
    chk(cur, rmac, m_rmac, "mac");
    chk(cur, rdb, m_rdb, "db");
  end

  task automatic ev(logic [3:0] k, logic [3:0] s, logic [11:0] d, logic [47:0] m, logic [10:0] p);
    ev_valid = 1; ev_kind = k; ev_src = s; ev_db = d; ev_mac = m; ev_pvec = p;
  endtask
  task automatic idle();
    ev_valid = 0; cmd_wr = 0;
  endtask
  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    chk("R1", {busy, irq, flags}, 0, "reset state");
    rst_n = 1; step(1);

    cur = "R1";
    ev(4'b0001, 4'd5, 12'h123, 48'h0011_2233_4455, 11'h404); step(1); idle();
    chk("R1", irq, 1, "irq after first event");

    cur = "R2";
    ev(4'b1000, 4'd9, 12'h777, 48'hAAAA_BBBB_CCCC, 11'h7FF); step(1); idle(); step(1);

    cur = "R3";
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle();
    chk("R5", irq, 0, "irq dropped after get-and-clear");
    for (int i = 0; i < BC; i++) begin chk("R3", busy, 1, "busy window"); step(1); end
    chk("R3", busy, 0, "busy cleared");
    chk("R4", flags, 4'b0001, "age flag");
    chk("R4", rdata[3:0], 5, "source port in low data field");
    chk("R4", rdata[14:4], 11'h404, "port vector");
    chk("R4", rmac, 48'h0011_2233_4455, "mac");
    chk("R4", rdb, 12'h123, "database");

    cur = "R7";
    step(2); chk("R7", flags, 4'b0001, "flags persist");
    cmd_wr = 1; cmd_op = 3'd2; step(1); idle();
    chk("R7", flags, 0, "flags cleared by other command");
    chk("R7", rmac, 48'h0011_2233_4455, "data kept");

    cur = "R8";
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle(); step(BC);
    chk("R8", {flags, rdata, rdb}, 0, "empty flags/data/db");
    chk("R8", rmac, 0, "empty mac");

    cur = "R10";
    ev(4'b0000, 4'd3, 12'h1, 48'h1, 11'h1); step(1); idle();
    chk("R10", irq, 0, "zero-kind event ignored");

    cur = "R6";
    ev(4'b0110, 4'd2, 12'h0A5, 48'h0102_0304_0506, 11'h003); step(1); idle(); step(1);
    cmd_wr = 1; cmd_op = 3'd7;
    ev(4'b1000, 4'd14, 12'hFED, 48'hFFEE_DDCC_BBAA, 11'h400); step(1); idle();
    chk("R6", irq, 1, "irq held by same-cycle event");
    step(BC);
    chk("R6", flags, 4'b0110, "old violation reported");
    chk("R6", rdata[3:0], 2, "old source port");
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle(); step(BC);
    chk("R6", flags, 4'b1000, "new violation flags");
    chk("R6", rdata, {11'h400, 4'd14}, "new data");
    chk("R6", rdb, 12'hFED, "new database");

    cur = "R9";
    ev(4'b0100, 4'd7, 12'h010, 48'h1234_5678_9ABC, 11'h080); step(1); idle();
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle();
    ev(4'b0010, 4'd1, 12'h020, 48'h5555_6666_7777, 11'h001); step(1); idle();
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle();
    chk("R9", irq, 1, "command while busy ignored");
    step(1); chk("R9", busy, 0, "busy length unchanged");
    chk("R9", flags, 4'b0100, "flags unchanged");
    cmd_wr = 1; cmd_op = 3'd7; step(1); idle(); step(BC);
    chk("R9", rmac, 48'h5555_6666_7777, "held event survived");

    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule